// File: doc/BRIEF.md
# USB Host Port Status and Wake Controller

This block holds the status and control state of one downstream port of a USB 2.0 host controller. Software reads and writes a single port word through a simple register interface. The block follows the port's connect, over-current and device-resume inputs. It keeps the enable, suspend, power, ownership and wake-enable state, together with the sticky change flags, and raises a global port-change-detect bit with an optional interrupt.

On over-current the block takes the port out of the enabled state and records the changes. A suspend request is held until the scheduler reports that no transaction is running. With the default setting it is also held until a frame or microframe boundary. Wake requests are filtered by per-event enable bits, except for resume signalling from a device, which always produces one.

All state is registered. A port input that changes before a clock edge is reflected in the port word, in `pcd` and in `wake_req` right after that edge.

Top module: `usb_port_status`

## Requirements
- R1: Every change of `oc_in`, rising or falling, sets the over-current-change flag (bit 5). Bit 4 shows the value of `oc_in` sampled at the last edge, and a write cannot change it.
- R2: The change flags (bit 1 connect, bit 3 enable, bit 5 over-current) are write-one-to-clear. A zero written to them leaves them unchanged. A hardware event in the same cycle as the clear wins.
- R3: A rising edge of `oc_in` clears the enabled bit (bit 2). If the port was enabled, it also sets the enable-change flag.
- R4: With the default `OC_POWER_OFF = 0`, the power bit (bit 8, reset value 1) stays set through an over-current event.
- R5: `pcd` is set when any change flag goes from zero to one. Only a `pcd_clr` pulse clears it. `irq` is high exactly while `pcd` and `pc_ie` are both high.
- R6: A write of one to the suspend bit (bit 7) is accepted only while the port is enabled and the owner bit (bit 9) is zero. Otherwise bit 7 stays zero.
- R7: An accepted suspend reads back on bit 7 at once. `port_susp` rises only at an edge where `xact_busy` is low and, with the default `SUSP_AT_BOUNDARY = 1`, `frame_tick` is high.
- R8: A rising edge of `resume_in` pulses `wake_req` for one cycle after the edge, whatever the wake-enable bits hold.
- R9: A rising edge of `conn_in`, a falling edge of `conn_in` and a rising edge of `oc_in` pulse `wake_req` only when bit 10, bit 11 and bit 12 respectively are set.
- R10: A written resume bit (bit 6) or a `resume_in` rising edge, while a suspend is pending or active, clears bit 7 and `port_susp`. The port stays enabled.
- R11: Bit 0 shows the sampled `conn_in`, and any change of `conn_in` sets bit 1. A disconnect clears the enabled bit and any suspend. Writing one to bit 2 enables the port only while it is connected and not over-current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the port word |
| wr_data | input | 13 | Port word write data |
| rd_data | output | 13 | Current port word |
| pcd_clr | input | 1 | Write-one clear of the port-change-detect bit |
| pc_ie | input | 1 | Port-change interrupt enable |
| oc_in | input | 1 | Over-current active from the port |
| conn_in | input | 1 | Device connected on the port |
| resume_in | input | 1 | Device resume signalling detected |
| xact_busy | input | 1 | A transaction is executing on the port |
| frame_tick | input | 1 | Frame or microframe boundary strobe |
| pcd | output | 1 | Global port-change-detect status |
| irq | output | 1 | Port-change interrupt |
| wake_req | output | 1 | One-cycle wake request |
| port_susp | output | 1 | Port is in the suspended state |

## Verification
The assertions take every port input to be a clean, synchronous level that is valid at each rising edge. They also take `pcd_clr` and `wr_en` to be single-cycle strobes. The assertion on resume keeping the port enabled assumes that no over-current, disconnect or disabling write arrives in the same cycle. The bench meets all of these by driving inputs only on the falling edge and asserting the strobes for exactly one cycle. It never combines a resume with a disabling event, and it always writes a full port word whose enable bit matches the intended state.

// File: rtl/usb_pstat_pkg.sv
package usb_pstat_pkg;
  localparam int PW     = 13;
  localparam int B_CONN = 0;
  localparam int B_CSC  = 1;
  localparam int B_EN   = 2;
  localparam int B_ENC  = 3;
  localparam int B_OCA  = 4;
  localparam int B_OCC  = 5;
  localparam int B_RES  = 6;
  localparam int B_SUSP = 7;
  localparam int B_PWR  = 8;
  localparam int B_OWN  = 9;
  localparam int B_WKC  = 10;
  localparam int B_WKD  = 11;
  localparam int B_WKO  = 12;

  function automatic logic is_rise(logic now_v, logic prev_v);
    return now_v & ~prev_v;
  endfunction

  function automatic logic is_fall(logic now_v, logic prev_v);
    return ~now_v & prev_v;
  endfunction

  // sticky flag: hardware set wins over a write-one clear
  function automatic logic flag_next(logic cur, logic set, logic wr, logic wbit);
    return set | (cur & ~(wr & wbit));
  endfunction

  function automatic logic newly_set(logic cur, logic set);
    return set & ~cur;
  endfunction
endpackage

// File: rtl/usb_pstat_sample.sv
module usb_pstat_sample #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= din[i];
    end
  end
endmodule

// File: rtl/usb_pstat_suspend.sv
module usb_pstat_suspend #(
  parameter bit AT_BOUNDARY = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic wake,
  input  logic abort,
  input  logic busy,
  input  logic tick,
  output logic pend,
  output logic act
);
  logic go;

  if (AT_BOUNDARY) begin : g_frame
    assign go = pend & ~busy & tick;
  end else begin : g_now
    assign go = pend & ~busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      act  <= 1'b0;
    end else if (abort || wake) begin
      pend <= 1'b0;
      act  <= 1'b0;
    end else if (go) begin
      pend <= 1'b0;
      act  <= 1'b1;
    end else if (req && !act) begin
      pend <= 1'b1;
    end
  end
endmodule

// File: rtl/usb_port_status.sv
module usb_port_status
  import usb_pstat_pkg::*;
#(
  parameter bit OC_POWER_OFF     = 1'b0,
  parameter bit SUSP_AT_BOUNDARY = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_data,
  output logic [PW-1:0] rd_data,
  input  logic          pcd_clr,
  input  logic          pc_ie,
  input  logic          oc_in,
  input  logic          conn_in,
  input  logic          resume_in,
  input  logic          xact_busy,
  input  logic          frame_tick,
  output logic          pcd,
  output logic          irq,
  output logic          wake_req,
  output logic          port_susp
);
  localparam int NSRC   = 3;
  localparam int S_OC   = 0;
  localparam int S_CONN = 1;
  localparam int S_RES  = 2;

  logic [NSRC-1:0] src_now, src_q;
  assign src_now = {resume_in, conn_in, oc_in};

  usb_pstat_sample #(.N(NSRC)) i_sample (
    .clk(clk), .rst_n(rst_n), .din(src_now), .q(src_q)
  );

  // named events
  logic oc_rise, oc_fall, oc_evt, conn_rise, conn_fall, conn_evt, res_rise;
  assign oc_rise   = is_rise(src_now[S_OC], src_q[S_OC]);
  assign oc_fall   = is_fall(src_now[S_OC], src_q[S_OC]);
  assign oc_evt    = oc_rise | oc_fall;
  assign conn_rise = is_rise(src_now[S_CONN], src_q[S_CONN]);
  assign conn_fall = is_fall(src_now[S_CONN], src_q[S_CONN]);
  assign conn_evt  = conn_rise | conn_fall;
  assign res_rise  = is_rise(src_now[S_RES], src_q[S_RES]);

  logic csc_q, en_q, enc_q, occ_q, pwr_q, own_q, wkc_q, wkd_q, wko_q, wake_q;
  logic susp_pend;

  // enable next state
  logic hw_drop, en_ok, en_n, port_drop;
  assign hw_drop = oc_rise | conn_fall;
  assign en_ok   = conn_in & ~oc_in;
  always_comb begin
    en_n = en_q;
    if (wr_en)   en_n = wr_data[B_EN] & (en_q | en_ok);
    if (hw_drop) en_n = 1'b0;
  end
  assign port_drop = en_q & ~en_n;

  // suspend and resume
  logic susp_req, sw_res, port_wake;
  assign susp_req  = wr_en & wr_data[B_SUSP] & en_q & ~own_q;
  assign sw_res    = wr_en & wr_data[B_RES];
  assign port_wake = (susp_pend | port_susp) & (sw_res | res_rise);

  usb_pstat_suspend #(.AT_BOUNDARY(SUSP_AT_BOUNDARY)) i_susp (
    .clk(clk), .rst_n(rst_n), .req(susp_req), .wake(port_wake),
    .abort(port_drop), .busy(xact_busy), .tick(frame_tick),
    .pend(susp_pend), .act(port_susp)
  );

  // change flags and port-change-detect
  logic enc_set, chg_new;
  assign enc_set = oc_rise & en_q;
  assign chg_new = newly_set(csc_q, conn_evt) | newly_set(enc_q, enc_set)
                 | newly_set(occ_q, oc_evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csc_q  <= 1'b0;
      en_q   <= 1'b0;
      enc_q  <= 1'b0;
      occ_q  <= 1'b0;
      pwr_q  <= 1'b1;
      own_q  <= 1'b0;
      wkc_q  <= 1'b0;
      wkd_q  <= 1'b0;
      wko_q  <= 1'b0;
      pcd    <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      csc_q <= flag_next(csc_q, conn_evt, wr_en, wr_data[B_CSC]);
      enc_q <= flag_next(enc_q, enc_set,  wr_en, wr_data[B_ENC]);
      occ_q <= flag_next(occ_q, oc_evt,   wr_en, wr_data[B_OCC]);
      en_q  <= en_n;
      if (wr_en) begin
        pwr_q <= wr_data[B_PWR];
        own_q <= wr_data[B_OWN];
        wkc_q <= wr_data[B_WKC];
        wkd_q <= wr_data[B_WKD];
        wko_q <= wr_data[B_WKO];
      end
      if (OC_POWER_OFF && oc_rise) pwr_q <= 1'b0;
      pcd    <= chg_new | (pcd & ~pcd_clr);
      wake_q <= res_rise | (conn_rise & wkc_q) | (conn_fall & wkd_q)
              | (oc_rise & wko_q);
    end
  end

  assign irq      = pcd & pc_ie;
  assign wake_req = wake_q;

  always_comb begin
    rd_data         = '0;
    rd_data[B_CONN] = src_q[S_CONN];
    rd_data[B_CSC]  = csc_q;
    rd_data[B_EN]   = en_q;
    rd_data[B_ENC]  = enc_q;
    rd_data[B_OCA]  = src_q[S_OC];
    rd_data[B_OCC]  = occ_q;
    rd_data[B_SUSP] = susp_pend | port_susp;
    rd_data[B_PWR]  = pwr_q;
    rd_data[B_OWN]  = own_q;
    rd_data[B_WKC]  = wkc_q;
    rd_data[B_WKD]  = wkd_q;
    rd_data[B_WKO]  = wko_q;
  end
endmodule

// File: rtl/usb_pstat_chk.sv
module usb_pstat_chk
  import usb_pstat_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [PW-1:0] wr_data,
  input logic [PW-1:0] rd_data,
  input logic          pcd_clr,
  input logic          oc_in,
  input logic          conn_in,
  input logic          xact_busy,
  input logic          oc_evt,
  input logic          oc_rise,
  input logic          res_rise,
  input logic          hw_drop,
  input logic          port_wake,
  input logic          en_q,
  input logic          own_q,
  input logic          occ_q,
  input logic          csc_q,
  input logic          susp_pend,
  input logic          port_susp,
  input logic          pcd,
  input logic          wake_req
);
  a_r1_oc_edge_flags: assert property (@(posedge clk) disable iff (!rst_n)
    oc_evt |=> occ_q);

  a_r1_oca_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[B_OCA] != oc_in)) |=> (rd_data[B_OCA] == $past(oc_in)));

  a_r11_conn_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[B_CONN] != conn_in)) |=> (rd_data[B_CONN] == $past(conn_in)));

  a_r2_zero_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (csc_q && !(wr_en && wr_data[B_CSC])) |=> csc_q);

  a_r3_oc_disables: assert property (@(posedge clk) disable iff (!rst_n)
    oc_rise |=> !en_q);

  a_r5_pcd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pcd && !pcd_clr) |=> pcd);

  a_r6_suspend_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_SUSP] && !(en_q && !own_q) && !susp_pend && !port_susp)
      |=> (!susp_pend && !port_susp));

  a_r7_not_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_susp) |-> !$past(xact_busy));

  a_r8_resume_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    res_rise |=> wake_req);

  a_r10_resume_keeps_en: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wake && !hw_drop && !(wr_en && !wr_data[B_EN]))
      |=> (en_q && !port_susp && !susp_pend));
endmodule

bind usb_port_status usb_pstat_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pcd_clr(pcd_clr), .oc_in(oc_in), .conn_in(conn_in),
  .xact_busy(xact_busy), .oc_evt(oc_evt), .oc_rise(oc_rise),
  .res_rise(res_rise), .hw_drop(hw_drop), .port_wake(port_wake),
  .en_q(en_q), .own_q(own_q), .occ_q(occ_q), .csc_q(csc_q),
  .susp_pend(susp_pend), .port_susp(port_susp), .pcd(pcd),
  .wake_req(wake_req)
);

// File: tb/test_usb_port_status.sv
`timescale 1ns/1ps
module test_usb_port_status;
  localparam logic [12:0] CONN = 13'h0001, CSC = 13'h0002, EN = 13'h0004,
                          ENC = 13'h0008, OCA = 13'h0010, OCC = 13'h0020,
                          RES = 13'h0040, SUSP = 13'h0080, PWR = 13'h0100,
                          OWN = 13'h0200, WKC = 13'h0400, WKD = 13'h0800,
                          WKO = 13'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [12:0] wr_data = '0;
  logic [12:0] rd_data;
  logic pcd_clr = 1'b0, pc_ie = 1'b0, oc_in = 1'b0, conn_in = 1'b0;
  logic resume_in = 1'b0, xact_busy = 1'b0, frame_tick = 1'b0;
  logic pcd, irq, wake_req, port_susp;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  usb_port_status i_usb_port_status (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pcd_clr(pcd_clr), .pc_ie(pc_ie), .oc_in(oc_in),
    .conn_in(conn_in), .resume_in(resume_in), .xact_busy(xact_busy),
    .frame_tick(frame_tick), .pcd(pcd), .irq(irq), .wake_req(wake_req),
    .port_susp(port_susp)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic bitset(input logic [12:0] w, input logic [12:0] m);
    return (w & m) != 0;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [12:0] w);
    wr_en = 1'b1; wr_data = w;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic clr_pcd();
    pcd_clr = 1'b1;
    step();
    pcd_clr = 1'b0;
  endtask

  task automatic pulse_tick();
    frame_tick = 1'b1;
    step();
    frame_tick = 1'b0;
  endtask

  task automatic t_reset();
    chk(rd_data, PWR, "R4 reset word power set");
    chk(pcd, 0, "R5 reset pcd");
    chk(wake_req, 0, "R8 reset wake");
    chk(port_susp, 0, "R7 reset suspend");
  endtask

  task automatic t_connect();
    pc_ie = 1'b1;
    conn_in = 1'b1; step();
    chk(bitset(rd_data, CONN), 1, "R11 connect shown");
    chk(bitset(rd_data, CSC), 1, "R11 connect change set");
    chk(pcd, 1, "R5 pcd on change");
    chk(irq, 1, "R5 irq with enable");
    wr(PWR);
    chk(bitset(rd_data, CSC), 1, "R2 zero write keeps flag");
    wr(PWR | CSC);
    chk(bitset(rd_data, CSC), 0, "R2 one write clears flag");
    chk(pcd, 1, "R5 pcd survives flag clear");
    clr_pcd();
    chk(pcd, 0, "R5 pcd cleared by own clear");
    chk(irq, 0, "R5 irq low after clear");
    wr(PWR | EN | CONN | OCA);
    chk(bitset(rd_data, EN), 1, "R11 enable when connected");
    chk(bitset(rd_data, OCA), 0, "R1 over-current bit read only");
  endtask

  task automatic t_overcurrent();
    pc_ie = 1'b0;
    oc_in = 1'b1; step();
    chk(bitset(rd_data, OCA), 1, "R1 over-current active shown");
    chk(bitset(rd_data, OCC), 1, "R1 rising sets change");
    chk(bitset(rd_data, EN), 0, "R3 over-current disables");
    chk(bitset(rd_data, ENC), 1, "R3 enable change set");
    chk(bitset(rd_data, PWR), 1, "R4 power stays on");
    chk(pcd, 1, "R5 pcd on over-current");
    chk(irq, 0, "R5 irq masked");
    chk(wake_req, 0, "R9 no wake, enable clear");
    wr(PWR | ENC | OCC);
    chk(rd_data & (ENC | OCC), 0, "R2 flags cleared");
    clr_pcd();
    oc_in = 1'b0; step();
    chk(bitset(rd_data, OCC), 1, "R1 falling sets change");
    chk(bitset(rd_data, ENC), 0, "R3 no enable change when disabled");
    chk(pcd, 1, "R5 pcd on falling change");
    oc_in = 1'b1; wr_en = 1'b1; wr_data = PWR | OCC;
    step();
    wr_en = 1'b0; wr_data = '0;
    chk(bitset(rd_data, OCC), 1, "R2 event wins over clear");
    oc_in = 1'b0; step();
    wr(PWR | OCC);
    clr_pcd();
  endtask

  task automatic t_wake_filter();
    wr(PWR | WKC | WKO);
    conn_in = 1'b0; step();
    chk(wake_req, 0, "R9 disconnect filtered");
    conn_in = 1'b1; step();
    chk(wake_req, 1, "R9 connect wakes");
    step();
    chk(wake_req, 0, "R9 wake is one cycle");
    oc_in = 1'b1; step();
    chk(wake_req, 1, "R9 over-current wakes");
    oc_in = 1'b0; step();
    chk(wake_req, 0, "R9 over-current fall no wake");
    wr(PWR | CSC | OCC);
    clr_pcd();
  endtask

  task automatic t_suspend_gate();
    wr(PWR | SUSP);
    chk(bitset(rd_data, SUSP), 0, "R6 suspend ignored when disabled");
    wr(PWR | EN | OWN);
    chk(bitset(rd_data, EN), 1, "R11 enable again");
    wr(PWR | EN | OWN | SUSP);
    chk(bitset(rd_data, SUSP), 0, "R6 suspend ignored when not owned");
    chk(port_susp, 0, "R6 not suspended");
    wr(PWR | EN);
  endtask

  task automatic t_suspend_defer();
    xact_busy = 1'b1;
    wr(PWR | EN | SUSP);
    chk(bitset(rd_data, SUSP), 1, "R7 suspend bit reads set");
    chk(port_susp, 0, "R7 not yet suspended");
    pulse_tick();
    chk(port_susp, 0, "R7 held while busy");
    xact_busy = 1'b0;
    step(); step();
    chk(port_susp, 0, "R7 waits for boundary");
    pulse_tick();
    chk(port_susp, 1, "R7 suspended at boundary");
  endtask

  task automatic t_resume();
    wr(PWR | EN | RES);
    chk(port_susp, 0, "R10 software resume");
    chk(bitset(rd_data, SUSP), 0, "R10 suspend bit cleared");
    chk(bitset(rd_data, EN), 1, "R10 still enabled");
    wr(PWR | EN | SUSP);
    pulse_tick();
    chk(port_susp, 1, "R7 suspended again");
    resume_in = 1'b1; step();
    chk(port_susp, 0, "R10 device resume");
    chk(bitset(rd_data, EN), 1, "R10 enabled after device resume");
    chk(wake_req, 1, "R8 resume wakes");
    resume_in = 1'b0; step();
    chk(wake_req, 0, "R8 wake one cycle");
    resume_in = 1'b1; step();
    chk(wake_req, 1, "R8 wake with all enables clear");
    resume_in = 1'b0; step();
  endtask

  task automatic t_disconnect();
    wr(PWR | EN | SUSP);
    pulse_tick();
    chk(port_susp, 1, "R7 suspended before disconnect");
    conn_in = 1'b0; step();
    chk(bitset(rd_data, EN), 0, "R11 disconnect disables");
    chk(port_susp, 0, "R11 disconnect drops suspend");
    chk(bitset(rd_data, SUSP), 0, "R11 suspend bit cleared");
    chk(wake_req, 0, "R9 disconnect wake disabled");
    wr(PWR | EN);
    chk(bitset(rd_data, EN), 0, "R11 enable refused when unconnected");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_connect();
    t_overcurrent();
    t_wake_filter();
    t_suspend_gate();
    t_suspend_defer();
    t_resume();
    t_disconnect();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule